// File: doc/BRIEF.md
# Outbound Link Frame Deserializer

This block sits on the codec side of a serial audio link and turns the outbound bit stream back into commands and PCM samples. It runs on the link bit clock and watches two lines. The sync line marks frame boundaries and carries a tag in front of each stream block. The data line carries two bits per clock period: one is taken on the rising edge and one on the falling edge. A frame starts after a frame-sync run on the sync line. The first sixteen clocks of the frame hold a 32-bit command word. Stream blocks follow. Each block is announced by an eight-clock tag on the sync line.

The block compares each tag with a programmed stream number and keeps only the blocks that match. It slices each matching block into samples of the configured width. The number of samples per block comes from the configured channel count. Each sample is sent out with a one-cycle strobe, its channel index, and the sample zero-extended to 24 bits. It skips blocks that belong to other stream numbers. It also ignores the zero padding at the end of a frame. If a tag has a malformed preamble, the block stops reading that frame until the next frame sync.

Top module: `ofd_outbound_rx`

## Requirements
- R1: While `rst_n` is low, `cmd_valid_o`, `cmd_word_o`, `pcm_valid_o`, `pcm_chan_o` and `pcm_data_o` are all zero. After reset, no strobe is produced until the first valid frame sync has been seen.
- R2: A frame sync is a run of at least SYNC_LEN (8) consecutive clocks with `sync_i` high, followed by a clock with `sync_i` low. That low clock is slot 0 of the frame. A run of seven high clocks starts no frame.
- R3: Each clock period supplies two data bits to the stream. The bit on `sdo_i` at the rising edge comes first, and the bit at the following falling edge comes second.
- R4: Slots 0 to 15 carry the 32-bit command word msb first. `cmd_valid_o` pulses for exactly one cycle, in the clock after slot 15, and `cmd_word_o` holds the word during that pulse.
- R5: After the command, a tag starts on the first clock with `sync_i` high. The tag is eight sync bits msb first: the preamble 1110 followed by a 4-bit stream number. Stream data starts in the clock right after the tag.
- R6: A block whose tag number equals `cfg_sid` holds `cfg_nch_m1`+1 samples, each sent msb first. The sample width is set by `cfg_width`: 0 selects 16 bits, 1 selects 20 bits, and 2 or 3 select 24 bits. Each sample gives one `pcm_valid_o` pulse, in the clock after its last data clock. During that pulse `pcm_chan_o` counts up from 0 through the block, and `pcm_data_o` holds the sample in its low bits with zeros above.
- R7: A block with a different stream number, of any width and length, produces no output. A tag that follows it is still recognised.
- R8: A tag whose preamble is not 1110 stops all command and sample output until the next frame sync. The frame after that is handled normally.
- R9: Zero padding on both lines after the last block produces no sample output, even when `cfg_sid` is 0.
- R10: Two tagged blocks with the same matching number in one frame are both extracted, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; both edges capture data |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync and stream tag line |
| sdo_i | input | 1 | Outbound data line, two bits per clock |
| cfg_sid | input | 4 | Stream number to extract |
| cfg_width | input | 2 | Sample width code (0:16, 1:20, 2/3:24) |
| cfg_nch_m1 | input | 3 | Samples per block minus one |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_word_o | output | 32 | Captured command word |
| pcm_valid_o | output | 1 | One-cycle sample strobe |
| pcm_chan_o | output | 3 | Sample index within the block |
| pcm_data_o | output | 24 | Zero-extended sample |

## Verification
Every result appears exactly one clock after the clock that carried its last bit. The command strobe comes one clock after slot 15. Each sample strobe comes one clock after the last data clock of that sample. The bench numbers every driven clock and builds each frame from bit arrays. From the same arrays it computes the clock number at which each strobe is due, together with its value. The monitor samples 3 ns after each rising edge, clear of both clock edges, and records the clock number of every strobe. The run is then compared event by event, by clock and by value, so an early strobe, a late strobe or a missing strobe all show up as a failure.

// File: rtl/ofd_pkg.sv
`timescale 1ns/1ps
package ofd_pkg;

  typedef enum logic [2:0] {
    ST_DEAD = 3'd0,
    ST_CMD  = 3'd1,
    ST_HUNT = 3'd2,
    ST_TAG  = 3'd3,
    ST_MINE = 3'd4
  } ofd_state_e;

  localparam logic [3:0] TAG_PREAMBLE = 4'b1110;

  // sample width in bits for a width code
  function automatic int width_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  // clock periods per sample (two bits per period)
  function automatic int width_slots(input logic [1:0] code);
    return width_bits(code) / 2;
  endfunction

endpackage

// File: rtl/ofd_ddr_capture.sv
`timescale 1ns/1ps
module ofd_ddr_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic sdo_i,
  output logic st_sync_o,
  output logic st_b0_o,
  output logic st_b1_o
);

  logic rise_q;
  logic fall_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      rise_q <= sdo_i;
      sync_q <= sync_i;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= sdo_i;
  end

  // one stage per clock: sync level and the two bits of that period
  assign st_sync_o = sync_q;
  assign st_b0_o   = rise_q;
  assign st_b1_o   = fall_q;

endmodule

// File: rtl/ofd_sync_detect.sv
`timescale 1ns/1ps
module ofd_sync_detect #(
  parameter int SYNC_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic st_sync,
  output logic fs_start
);

  localparam int RUN_W = $clog2(SYNC_LEN + 1);

  logic [RUN_W-1:0] run_q;
  logic             run_full;

  assign run_full = (run_q == RUN_W'(SYNC_LEN));
  assign fs_start = !st_sync && run_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (!st_sync) run_q <= '0;
    else if (!run_full) run_q <= run_q + RUN_W'(1);
  end

endmodule

// File: rtl/ofd_frame_fsm.sv
`timescale 1ns/1ps
module ofd_frame_fsm
  import ofd_pkg::*;
#(
  parameter int CMD_BITS = 32,
  parameter int SID_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fs_start,
  input  logic               st_sync,
  input  logic               st_b0,
  input  logic               st_b1,
  input  logic [SID_W-1:0]   cfg_sid,
  input  logic               blk_last,
  output logic               cmd_valid_o,
  output logic [CMD_BITS-1:0] cmd_word_o,
  output logic               tag_hit,
  output ofd_state_e         state_o
);

  localparam int CMD_SLOTS = CMD_BITS / 2;
  localparam int TAG_BITS  = 4 + SID_W;
  localparam int CC_W      = $clog2(CMD_SLOTS);
  localparam int TC_W      = $clog2(TAG_BITS);

  ofd_state_e          state_q;
  logic [CMD_BITS-1:0] cmd_sh;
  logic [CMD_BITS-1:0] cmd_next;
  logic [CC_W-1:0]     ccnt;
  logic [TAG_BITS-1:0] tag_sh;
  logic [TAG_BITS-1:0] tag_next;
  logic [TC_W-1:0]     tcnt;
  logic                tag_end;
  logic                pre_ok;
  logic                id_ok;

  assign cmd_next = {cmd_sh[CMD_BITS-3:0], st_b0, st_b1};
  assign tag_next = {tag_sh[TAG_BITS-2:0], st_sync};
  assign tag_end  = (state_q == ST_TAG) && (tcnt == TC_W'(TAG_BITS - 1));
  assign pre_ok   = (tag_next[TAG_BITS-1 -: 4] == TAG_PREAMBLE);
  assign id_ok    = (tag_next[SID_W-1:0] == cfg_sid);
  assign tag_hit  = tag_end && pre_ok && id_ok && !fs_start;
  assign state_o  = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_DEAD;
      cmd_sh      <= '0;
      ccnt        <= '0;
      tag_sh      <= '0;
      tcnt        <= '0;
      cmd_valid_o <= 1'b0;
      cmd_word_o  <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (fs_start) begin
        state_q <= ST_CMD;
        cmd_sh  <= cmd_next;
        ccnt    <= CC_W'(1);
      end else begin
        case (state_q)
          ST_CMD: begin
            cmd_sh <= cmd_next;
            if (ccnt == CC_W'(CMD_SLOTS - 1)) begin
              cmd_valid_o <= 1'b1;
              cmd_word_o  <= cmd_next;
              state_q     <= ST_HUNT;
            end else begin
              ccnt <= ccnt + CC_W'(1);
            end
          end
          ST_HUNT: begin
            if (st_sync) begin
              tag_sh  <= TAG_BITS'(1);
              tcnt    <= TC_W'(1);
              state_q <= ST_TAG;
            end
          end
          ST_TAG: begin
            tag_sh <= tag_next;
            tcnt   <= tcnt + TC_W'(1);
            if (tag_end) begin
              if (!pre_ok)    state_q <= ST_DEAD;
              else if (id_ok) state_q <= ST_MINE;
              else            state_q <= ST_HUNT;
            end
          end
          ST_MINE: begin
            if (blk_last) state_q <= ST_HUNT;
          end
          default: state_q <= ST_DEAD;
        endcase
      end
    end
  end

  // R2
  fs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_start |=> (state_q == ST_CMD));

  // R4
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R4
  cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(state_q == ST_CMD));

  // R8
  dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEAD && !fs_start) |=> (state_q == ST_DEAD));

endmodule

// File: rtl/ofd_slicer.sv
`timescale 1ns/1ps
module ofd_slicer
  import ofd_pkg::*;
#(
  parameter int PCM_W  = 24,
  parameter int MAX_CH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fs_start,
  input  logic                tag_hit,
  input  logic [1:0]          cfg_width,
  input  logic [((MAX_CH > 1) ? $clog2(MAX_CH) : 1)-1:0] cfg_nch_m1,
  input  logic                st_b0,
  input  logic                st_b1,
  output logic                pcm_valid_o,
  output logic [((MAX_CH > 1) ? $clog2(MAX_CH) : 1)-1:0] pcm_chan_o,
  output logic [PCM_W-1:0]    pcm_data_o,
  output logic                busy_o,
  output logic                blk_last
);

  localparam int CH_W   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;
  localparam int SLOT_W = $clog2(PCM_W / 2);

  logic              busy_q;
  logic [1:0]        blk_w;
  logic [CH_W-1:0]   blk_nch;
  logic [SLOT_W-1:0] slot;
  logic [CH_W-1:0]   ch;
  logic [PCM_W-1:0]  smp;
  logic [PCM_W-1:0]  smp_next;
  logic              smp_end;

  // keep the low nbits of a shifted sample, clear the rest
  function automatic logic [PCM_W-1:0] keep_low(input logic [PCM_W-1:0] v,
                                               input int nbits);
    logic [PCM_W-1:0] m;
    for (int i = 0; i < PCM_W; i++) m[i] = (i < nbits);
    return v & m;
  endfunction

  assign smp_next = {smp[PCM_W-3:0], st_b0, st_b1};
  assign smp_end  = busy_q && (slot == SLOT_W'(width_slots(blk_w) - 1));
  assign blk_last = smp_end && (ch == blk_nch);
  assign busy_o   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      blk_w       <= '0;
      blk_nch     <= '0;
      slot        <= '0;
      ch          <= '0;
      smp         <= '0;
      pcm_valid_o <= 1'b0;
      pcm_chan_o  <= '0;
      pcm_data_o  <= '0;
    end else begin
      pcm_valid_o <= 1'b0;
      if (fs_start) begin
        busy_q <= 1'b0;
      end else if (tag_hit) begin
        busy_q  <= 1'b1;
        blk_w   <= cfg_width;
        blk_nch <= cfg_nch_m1;
        slot    <= '0;
        ch      <= '0;
      end else if (busy_q) begin
        smp <= smp_next;
        if (smp_end) begin
          pcm_valid_o <= 1'b1;
          pcm_chan_o  <= ch;
          pcm_data_o  <= keep_low(smp_next, width_bits(blk_w));
          slot        <= '0;
          if (ch == blk_nch) busy_q <= 1'b0;
          else               ch <= ch + CH_W'(1);
        end else begin
          slot <= slot + SLOT_W'(1);
        end
      end
    end
  end

  // R6
  pcm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid_o |-> $past(busy_q));

  // R6
  pcm_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid_o |-> (pcm_chan_o <= blk_nch));

  // R10
  pcm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid_o |=> !pcm_valid_o);

endmodule

// File: rtl/ofd_outbound_rx.sv
`timescale 1ns/1ps
module ofd_outbound_rx
  import ofd_pkg::*;
#(
  parameter int SYNC_LEN = 8,
  parameter int CMD_BITS = 32,
  parameter int SID_W    = 4,
  parameter int PCM_W    = 24,
  parameter int MAX_CH   = 8,
  localparam int CH_W    = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_i,
  input  logic                sdo_i,
  input  logic [SID_W-1:0]    cfg_sid,
  input  logic [1:0]          cfg_width,
  input  logic [CH_W-1:0]     cfg_nch_m1,
  output logic                cmd_valid_o,
  output logic [CMD_BITS-1:0] cmd_word_o,
  output logic                pcm_valid_o,
  output logic [CH_W-1:0]     pcm_chan_o,
  output logic [PCM_W-1:0]    pcm_data_o
);

  logic       st_sync;
  logic       st_b0;
  logic       st_b1;
  logic       fs_start;
  logic       tag_hit;
  logic       blk_last;
  logic       slc_busy;
  ofd_state_e fsm_state;

  ofd_ddr_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .sdo_i     (sdo_i),
    .st_sync_o (st_sync),
    .st_b0_o   (st_b0),
    .st_b1_o   (st_b1)
  );

  ofd_sync_detect #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_sync  (st_sync),
    .fs_start (fs_start)
  );

  ofd_frame_fsm #(.CMD_BITS(CMD_BITS), .SID_W(SID_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs_start    (fs_start),
    .st_sync     (st_sync),
    .st_b0       (st_b0),
    .st_b1       (st_b1),
    .cfg_sid     (cfg_sid),
    .blk_last    (blk_last),
    .cmd_valid_o (cmd_valid_o),
    .cmd_word_o  (cmd_word_o),
    .tag_hit     (tag_hit),
    .state_o     (fsm_state)
  );

  ofd_slicer #(.PCM_W(PCM_W), .MAX_CH(MAX_CH)) u_slc (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs_start    (fs_start),
    .tag_hit     (tag_hit),
    .cfg_width   (cfg_width),
    .cfg_nch_m1  (cfg_nch_m1),
    .st_b0       (st_b0),
    .st_b1       (st_b1),
    .pcm_valid_o (pcm_valid_o),
    .pcm_chan_o  (pcm_chan_o),
    .pcm_data_o  (pcm_data_o),
    .busy_o      (slc_busy),
    .blk_last    (blk_last)
  );

  // R6
  mine_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_MINE) == slc_busy);

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_DEAD && $past(fsm_state == ST_DEAD)) |-> !pcm_valid_o && !cmd_valid_o);

endmodule

// File: tb/tb_ofd_outbound_rx.sv
`timescale 1ns/1ps
module tb_ofd_outbound_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic        sdo_i = 1'b0;
  logic [3:0]  cfg_sid = 4'd5;
  logic [1:0]  cfg_width = 2'd0;
  logic [2:0]  cfg_nch_m1 = 3'd1;
  logic        cmd_valid_o;
  logic [31:0] cmd_word_o;
  logic        pcm_valid_o;
  logic [2:0]  pcm_chan_o;
  logic [23:0] pcm_data_o;

  always #2.5 clk = ~clk;

  ofd_outbound_rx dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sdo_i(sdo_i),
    .cfg_sid(cfg_sid), .cfg_width(cfg_width), .cfg_nch_m1(cfg_nch_m1),
    .cmd_valid_o(cmd_valid_o), .cmd_word_o(cmd_word_o),
    .pcm_valid_o(pcm_valid_o), .pcm_chan_o(pcm_chan_o), .pcm_data_o(pcm_data_o)
  );

  int  cyc = 0;
  int  ntests = 0;
  int  nfail = 0;
  bit  finished = 0;

  logic s_a [0:499];
  logic r_a [0:499];
  logic f_a [0:499];

  int          ecmd_c[$], epcm_c[$], ocmd_c[$], opcm_c[$];
  logic [31:0] ecmd_v[$], epcm_v[$], ocmd_v[$], opcm_v[$];

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (cmd_valid_o) begin ocmd_c.push_back(cyc); ocmd_v.push_back(cmd_word_o); end
      if (pcm_valid_o) begin
        opcm_c.push_back(cyc);
        opcm_v.push_back({5'd0, pcm_chan_o, pcm_data_o});
      end
    end
  end

  function automatic int bits_of(input logic [1:0] code);
    return (code == 2'd0) ? 16 : ((code == 2'd1) ? 20 : 24);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(ocmd_c.size() == ecmd_c.size(), req, "command count", ocmd_c.size(), ecmd_c.size());
    for (int i = 0; i < ocmd_c.size() && i < ecmd_c.size(); i++) begin
      chk(ocmd_c[i] == ecmd_c[i], req, "command cycle", ocmd_c[i], ecmd_c[i]);
      chk(ocmd_v[i] == ecmd_v[i], req, "command word", ocmd_v[i], ecmd_v[i]);
    end
    chk(opcm_c.size() == epcm_c.size(), req, "sample count", opcm_c.size(), epcm_c.size());
    for (int i = 0; i < opcm_c.size() && i < epcm_c.size(); i++) begin
      chk(opcm_c[i] == epcm_c[i], req, "sample cycle", opcm_c[i], epcm_c[i]);
      chk(opcm_v[i] == epcm_v[i], req, "sample chan/data", opcm_v[i], epcm_v[i]);
    end
    ocmd_c.delete(); ocmd_v.delete(); opcm_c.delete(); opcm_v.delete();
    ecmd_c.delete(); ecmd_v.delete(); epcm_c.delete(); epcm_v.delete();
  endtask

  task automatic new_frame(input int tail_start);
    for (int j = 0; j < 500; j++) begin
      s_a[j] = (j >= tail_start);
      r_a[j] = 1'b0;
      f_a[j] = 1'b0;
    end
  endtask

  // bit i of the stream: rising half of clock start+i/2 when i is even
  task automatic put_bits(input int start, input logic [31:0] val, input int n);
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0) r_a[start + i / 2] = val[n - 1 - i];
      else            f_a[start + i / 2] = val[n - 1 - i];
    end
  endtask

  task automatic put_cmd(input int base, input logic [31:0] w, input bit synced);
    put_bits(0, w, 32);
    if (synced) begin ecmd_c.push_back(base + 16); ecmd_v.push_back(w); end
  endtask

  task automatic add_stream(input int base, inout int pos, input logic [3:0] pre,
                            input logic [3:0] sid, input logic [1:0] wc,
                            input int nch, input bit want);
    logic [7:0]  tag;
    logic [31:0] smp;
    int          w;
    tag = {pre, sid};
    for (int i = 0; i < 8; i++) s_a[pos + i] = tag[7 - i];
    pos += 8;
    w = bits_of(wc);
    for (int c = 0; c < nch; c++) begin
      smp = $urandom & ((32'd1 << w) - 32'd1);
      put_bits(pos, smp, w);
      pos += w / 2;
      if (want) begin
        epcm_c.push_back(base + pos);
        epcm_v.push_back({5'd0, 3'(c), smp[23:0]});
      end
    end
  endtask

  task automatic drive_frame();
    for (int j = 0; j < 500; j++) begin
      sync_i = s_a[j];
      sdo_i  = r_a[j];
      @(posedge clk);
      #1 sdo_i = f_a[j];
      #3;
    end
  endtask

  task automatic idle_clocks(input int n, input logic s);
    for (int j = 0; j < n; j++) begin
      sync_i = s; sdo_i = 1'b0;
      @(posedge clk);
      #4;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got 0 expected 1");
      summary();
    end
  end

  initial begin
    int base;
    int pos;
    logic [31:0] w;
    void'($urandom(32'd7301));
    // R1: reset state
    #7;
    chk(!cmd_valid_o && cmd_word_o == 0, "R1", "cmd in reset", {cmd_valid_o, cmd_word_o}, 0);
    chk(!pcm_valid_o && pcm_chan_o == 0 && pcm_data_o == 0, "R1", "pcm in reset",
        {pcm_valid_o, pcm_chan_o, pcm_data_o}, 0);
    @(posedge clk); #4;
    rst_n = 1'b1;
    idle_clocks(20, 1'b0);
    compare("R1 idle");

    // R1: a frame before any frame sync gives nothing
    base = cyc + 1;
    new_frame(492);
    put_cmd(base, 32'h1234_5678, 0);
    pos = 16;
    add_stream(base, pos, 4'b1110, 4'd5, 2'd0, 2, 0);
    drive_frame();
    compare("R1 unsynced");

    // R3 R4 R5 R6: directed frame
    base = cyc + 1;
    new_frame(492);
    put_cmd(base, 32'hA5C3_0F1E, 1);
    pos = 16;
    add_stream(base, pos, 4'b1110, 4'd5, 2'd0, 2, 1);
    drive_frame();
    compare("R3 R4 R5 R6");

    // R7: foreign blocks around a matching one
    cfg_width = 2'd1; cfg_nch_m1 = 3'd3;
    base = cyc + 1;
    new_frame(492);
    put_cmd(base, 32'h0BAD_F00D, 1);
    pos = 16;
    add_stream(base, pos, 4'b1110, 4'd2, 2'd2, 3, 0);
    add_stream(base, pos, 4'b1110, 4'd5, 2'd1, 4, 1);
    add_stream(base, pos, 4'b1110, 4'd9, 2'd0, 8, 0);
    drive_frame();
    compare("R7");

    // R8: bad preamble, then matching tag in the same frame is ignored
    base = cyc + 1;
    new_frame(492);
    put_cmd(base, 32'hFFFF_0001, 1);
    pos = 16;
    add_stream(base, pos, 4'b1010, 4'd5, 2'd1, 4, 0);
    add_stream(base, pos, 4'b1110, 4'd5, 2'd1, 4, 0);
    drive_frame();
    compare("R8 dead");
    base = cyc + 1;
    new_frame(492);
    put_cmd(base, 32'h8000_0000, 1);
    pos = 16;
    add_stream(base, pos, 4'b1110, 4'd5, 2'd1, 4, 1);
    drive_frame();
    compare("R8 recover");

    // R9: null field with stream number 0
    cfg_sid = 4'd0;
    base = cyc + 1;
    new_frame(492);
    put_cmd(base, 32'h0000_0000, 1);
    drive_frame();
    compare("R9");

    // R10: two matching blocks in one frame; tail run of 7 only (R2)
    cfg_sid = 4'd12; cfg_width = 2'd3; cfg_nch_m1 = 3'd5;
    base = cyc + 1;
    new_frame(493);
    put_cmd(base, 32'h5A5A_A5A5, 1);
    pos = 16;
    add_stream(base, pos, 4'b1110, 4'd12, 2'd3, 6, 1);
    add_stream(base, pos, 4'b1110, 4'd3, 2'd0, 1, 0);
    add_stream(base, pos, 4'b1110, 4'd12, 2'd3, 6, 1);
    drive_frame();
    compare("R10");

    // R2: previous run was 7 clocks, so this frame is not started
    base = cyc + 1;
    new_frame(488);
    put_cmd(base, 32'hDEAD_BEEF, 0);
    pos = 16;
    add_stream(base, pos, 4'b1110, 4'd12, 2'd3, 6, 0);
    drive_frame();
    compare("R2 short run");

    // R2: a 12-clock run still starts the frame
    base = cyc + 1;
    new_frame(492);
    put_cmd(base, 32'h0F0F_F0F0, 1);
    pos = 16;
    add_stream(base, pos, 4'b1110, 4'd12, 2'd3, 6, 1);
    drive_frame();
    compare("R2 long run");

    // R6 R7: random frames
    for (int k = 0; k < 24; k++) begin
      int nstr;
      cfg_sid    = 4'($urandom);
      cfg_width  = 2'($urandom);
      cfg_nch_m1 = 3'($urandom);
      base = cyc + 1;
      new_frame(492);
      w = $urandom;
      put_cmd(base, w, 1);
      pos = 16;
      nstr = 1 + $urandom % 3;
      for (int s = 0; s < nstr; s++) begin
        if ($urandom % 2 == 0)
          add_stream(base, pos, 4'b1110, cfg_sid, cfg_width, int'(cfg_nch_m1) + 1, 1);
        else
          add_stream(base, pos, 4'b1110, cfg_sid ^ 4'(1 + $urandom % 15),
                     2'($urandom), 1 + $urandom % 8, 0);
      end
      drive_frame();
      compare("R6 R7 random");
    end

    summary();
  end

endmodule